// File: doc/BRIEF.md
# Recursive Aggressor Bit Locator

This block finds the one bit position in a memory row whose data change disturbs a known failing victim bit. The address map inside the row is scrambled, so the disturbing neighbour can sit at any logical offset from the victim. Checking every pair of addresses would cost a number of tests that grows with the square of the row width. The block instead runs a binary-partition search. Each test inverts a contiguous, aligned window of candidate addresses while the victim holds its sensitive value. An external test executor performs the write, wait and read-check sequence and returns pass or fail.

A search starts from the whole row. At each level the lower half of the current window is tested first. If that test fails, the search keeps the lower half. If it passes, the upper half is tested, and a failure there keeps the upper half. If both halves pass, the search stops and reports not-found. When the window has shrunk to one bit, the block reports that address and its signed distance from the victim. The method relies on strongly dependent victims, which fail when a single neighbour changes. One search locates one neighbour. Searches in several rows can be merged to recover both neighbour offsets.

Top module: `aggressor_locator`

## Requirements
- R1: After reset the block is idle: `busy`, `reqValid` and `doneValid` are all 0.
- R2: The first test of a search covers the lower half of the row: `reqStart` is 0 and `reqLen` is ROW_BITS/2.
- R3: Every request window has a power-of-two length and is aligned to that length. At each level the lower half is requested first. The upper half (`reqStart` of the lower half plus `reqLen`) is requested only after the lower half passes.
- R4: A failing test narrows the window to the tested half. A search that finds its target issues exactly log2(ROW_BITS) + popcount(target address) tests.
- R5: If both halves at a level pass, the search ends with `doneValid`=1 and `found`=0, after exactly two tests at the first level when no bit in the row disturbs the victim.
- R6: A finished search that located the bit reports `found`=1, `foundAddr` equal to the located address, and `foundOffset` equal to foundAddr minus the victim address as a two's-complement value. `doneValid` is high for exactly one cycle.
- R7: `reqHasVictim` is 1 exactly when the victim address lies inside the requested window [reqStart, reqStart+reqLen). The executor must then leave the victim bit out of the inverted set.
- R8: `start` has no effect while `busy` is 1. The running search keeps the victim address captured at its own start.
- R9: `reqValid` is a one-cycle pulse. `reqStart` and `reqLen` stay stable until `rspValid` returns the result of that request, and only one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (ignored while busy) |
| victimAddr | input | AW | Address of the failing victim bit, captured at start |
| busy | output | 1 | A search is in progress |
| reqValid | output | 1 | One-cycle pulse issuing a test request |
| reqStart | output | AW | First address of the window to invert |
| reqLen | output | AW+1 | Number of addresses in the window |
| reqHasVictim | output | 1 | Victim lies inside the window and must not be inverted |
| rspValid | input | 1 | Test result is valid |
| rspFail | input | 1 | The victim failed during the test |
| doneValid | output | 1 | One-cycle pulse when the search ends |
| found | output | 1 | 1 when a location was found, 0 for not-found |
| foundAddr | output | AW | Located neighbour address |
| foundOffset | output | AW+1 | Signed offset foundAddr minus victim address |

## Verification
The assertions assume that the executor answers each request with exactly one `rspValid` pulse, and only while a request is outstanding. They also assume that `rspValid` never arrives in the same cycle as the request pulse. The bench meets this with a model that counts down a delay of one to three cycles after it sees `reqValid` before it answers. That model fails a test only when the hidden disturbing address lies in the window and is not the victim. The bench sweeps every victim and disturbing-address pair of a 16-bit row, plus a no-neighbour case for each victim. It computes the expected address, offset, test count and victim-overlap flag arithmetically.

// File: rtl/aggressor_locator_pkg.sv
package aggressor_locator_pkg;
  typedef struct packed {
    logic load;       // capture victim, reset window to whole row
    logic selUpper;   // request addresses the upper half
    logic takeUpper;  // move window base to upper half
    logic shrink;     // halve window length
    logic markFound;  // record successful location
  } locStrobes_t;
endpackage

// File: rtl/aggressor_locator_dp.sv
module aggressor_locator_dp
  import aggressor_locator_pkg::*;
#(
  parameter int ROW_BITS = 64,
  localparam int AW = $clog2(ROW_BITS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  locStrobes_t       strobe,
  input  logic [AW-1:0]     victimAddr,
  output logic              lastLevel,
  output logic [AW-1:0]     reqStart,
  output logic [AW:0]       reqLen,
  output logic              reqHasVictim,
  output logic              found,
  output logic [AW-1:0]     foundAddr,
  output logic [AW:0]       foundOffset
);
  localparam logic [AW:0] FULL_LEN = (AW+1)'(ROW_BITS);

  logic [AW-1:0] winBase;
  logic [AW:0]   winLen;
  logic [AW-1:0] victimQ;
  logic          foundQ;
  logic [AW:0]   halfLen;
  logic [AW:0]   winEnd;

  assign halfLen = winLen >> 1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winBase <= '0;
      winLen  <= FULL_LEN;
      victimQ <= '0;
      foundQ  <= 1'b0;
    end else if (strobe.load) begin
      winBase <= '0;
      winLen  <= FULL_LEN;
      victimQ <= victimAddr;
      foundQ  <= 1'b0;
    end else begin
      if (strobe.takeUpper) winBase <= winBase + halfLen[AW-1:0];
      if (strobe.shrink)    winLen  <= halfLen;
      if (strobe.markFound) foundQ  <= 1'b1;
    end
  end

  assign lastLevel    = (halfLen == (AW+1)'(1));
  assign reqStart     = strobe.selUpper ? winBase + halfLen[AW-1:0] : winBase;
  assign reqLen       = halfLen;
  assign winEnd       = {1'b0, reqStart} + reqLen;
  assign reqHasVictim = ({1'b0, victimQ} >= {1'b0, reqStart}) && ({1'b0, victimQ} < winEnd);
  assign found        = foundQ;
  assign foundAddr    = winBase;
  assign foundOffset  = {1'b0, winBase} - {1'b0, victimQ};
endmodule

// File: rtl/aggressor_locator_ctrl.sv
module aggressor_locator_ctrl
  import aggressor_locator_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        rspValid,
  input  logic        rspFail,
  input  logic        lastLevel,
  output locStrobes_t strobe,
  output logic        busy,
  output logic        reqValid,
  output logic        doneValid
);
  typedef enum logic [2:0] {
    S_IDLE, S_ASK_LO, S_WAIT_LO, S_ASK_HI, S_WAIT_HI, S_FINISH
  } locState_t;

  locState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    strobe.selUpper = (state == S_ASK_HI) || (state == S_WAIT_HI);
    case (state)
      S_IDLE: if (start) begin
        strobe.load = 1'b1;
        nextState   = S_ASK_LO;
      end
      S_ASK_LO: nextState = S_WAIT_LO;
      S_WAIT_LO: if (rspValid) begin
        if (rspFail) begin
          strobe.shrink    = 1'b1;
          strobe.markFound = lastLevel;
          nextState        = lastLevel ? S_FINISH : S_ASK_LO;
        end else begin
          nextState = S_ASK_HI;
        end
      end
      S_ASK_HI: nextState = S_WAIT_HI;
      S_WAIT_HI: if (rspValid) begin
        if (rspFail) begin
          strobe.takeUpper = 1'b1;
          strobe.shrink    = 1'b1;
          strobe.markFound = lastLevel;
          nextState        = lastLevel ? S_FINISH : S_ASK_LO;
        end else begin
          nextState = S_FINISH;
        end
      end
      S_FINISH: nextState = S_IDLE;
      default:  nextState = S_IDLE;
    endcase
  end

  assign busy      = (state != S_IDLE);
  assign reqValid  = (state == S_ASK_LO) || (state == S_ASK_HI);
  assign doneValid = (state == S_FINISH);
endmodule

// File: rtl/aggressor_locator.sv
module aggressor_locator
  import aggressor_locator_pkg::*;
#(
  parameter int ROW_BITS = 64,
  localparam int AW = $clog2(ROW_BITS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [AW-1:0] victimAddr,
  output logic          busy,
  output logic          reqValid,
  output logic [AW-1:0] reqStart,
  output logic [AW:0]   reqLen,
  output logic          reqHasVictim,
  input  logic          rspValid,
  input  logic          rspFail,
  output logic          doneValid,
  output logic          found,
  output logic [AW-1:0] foundAddr,
  output logic [AW:0]   foundOffset
);
  locStrobes_t strobe;
  logic        lastLevel;

  aggressor_locator_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .rspValid(rspValid),
    .rspFail(rspFail), .lastLevel(lastLevel), .strobe(strobe),
    .busy(busy), .reqValid(reqValid), .doneValid(doneValid)
  );

  aggressor_locator_dp #(.ROW_BITS(ROW_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .victimAddr(victimAddr),
    .lastLevel(lastLevel), .reqStart(reqStart), .reqLen(reqLen),
    .reqHasVictim(reqHasVictim), .found(found), .foundAddr(foundAddr),
    .foundOffset(foundOffset)
  );
endmodule

// File: rtl/aggressor_locator_chk.sv
module aggressor_locator_chk #(
  parameter int ROW_BITS = 64,
  localparam int AW = $clog2(ROW_BITS)
) (
  input logic          clk,
  input logic          rstN,
  input logic          busy,
  input logic          reqValid,
  input logic [AW-1:0] reqStart,
  input logic [AW:0]   reqLen,
  input logic          rspValid,
  input logic          doneValid
);
  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !reqValid && !doneValid);

  a_r3_len_pow2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $countones(reqLen) == 1);

  a_r3_aligned: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (({1'b0, reqStart} & (reqLen - 1'b1)) == '0));

  a_r9_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> !reqValid);

  a_r9_req_stable: assert property (@(posedge clk) disable iff (!rstN)
    $past(reqValid) && !$past(rspValid) && busy |-> $stable(reqStart) && $stable(reqLen));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  a_r6_done_after_rsp: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(rspValid));
endmodule

bind aggressor_locator aggressor_locator_chk #(.ROW_BITS(ROW_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .reqValid(reqValid),
  .reqStart(reqStart), .reqLen(reqLen), .rspValid(rspValid),
  .doneValid(doneValid)
);

// File: tb/sim_aggressor_locator.sv
module sim_aggressor_locator;
  localparam int ROW = 16;
  localparam int AW  = $clog2(ROW);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] victimAddr = '0;
  logic          busy, reqValid, reqHasVictim, doneValid, found;
  logic [AW-1:0] reqStart, foundAddr;
  logic [AW:0]   reqLen, foundOffset;
  logic          rspValid = 1'b0;
  logic          rspFail = 1'b0;

  int testsRun = 0;
  int testsFailed = 0;

  always #5 clk = ~clk;

  aggressor_locator #(.ROW_BITS(ROW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .victimAddr(victimAddr),
    .busy(busy), .reqValid(reqValid), .reqStart(reqStart), .reqLen(reqLen),
    .reqHasVictim(reqHasVictim), .rspValid(rspValid), .rspFail(rspFail),
    .doneValid(doneValid), .found(found), .foundAddr(foundAddr),
    .foundOffset(foundOffset)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Run one search. aggr < 0 means no disturbing bit in the row.
  task automatic runCase(input int v, input int aggr, input bit midStart);
    int nReq = 0, waitCnt = 0, lastS = -1, lastL = 0, expLen = ROW / 2;
    int expTests, pend = 0, curLo = 0;
    bit seqOk = 1'b1, victimOk = 1'b1, firstOk = 1'b1, done = 1'b0, pendUpper = 1'b0;
    @(negedge clk);
    victimAddr = AW'(v);
    start = 1'b1;
    for (int cyc = 0; cyc < 400 && !done; cyc++) begin
      @(negedge clk);
      start = 1'b0;
      rspValid = 1'b0;
      if (waitCnt > 0) begin
        waitCnt--;
        if (waitCnt == 0) begin
          rspValid = 1'b1;
          rspFail  = (aggr >= 0) && (aggr != v) && (aggr >= lastS) && (aggr < lastS + lastL);
        end
      end else if (reqValid) begin
        lastS = int'(reqStart);
        lastL = int'(reqLen);
        if (nReq == 0 && (lastS != 0 || lastL != ROW / 2)) firstOk = 1'b0;
        // expected window: lower half first, upper only after lower passed
        if (pendUpper) begin
          if (lastS != curLo + expLen || lastL != expLen) seqOk = 1'b0;
        end else begin
          if (lastS != curLo || lastL != expLen) seqOk = 1'b0;
        end
        if (reqHasVictim !== ((v >= lastS) && (v < lastS + lastL))) victimOk = 1'b0;
        nReq++;
        waitCnt = 1 + ((v + nReq) % 3);
        if (midStart && nReq == 1) begin
          start = 1'b1;
          victimAddr = AW'((v + 5) % ROW);
        end
      end
      // model window update after the response is issued this cycle
      if (rspValid) begin
        if (rspFail) begin
          if (pendUpper) curLo = curLo + expLen;
          expLen = expLen / 2;
          pendUpper = 1'b0;
        end else begin
          pendUpper = !pendUpper;
        end
      end
      if (doneValid) done = 1'b1;
    end
    check(done, "R6 done seen", int'(done), 1);
    check(firstOk, "R2 first window", lastS, 0);
    check(seqOk, "R3 window order", lastS, curLo);
    check(victimOk, "R7 victim flag", int'(reqHasVictim), 0);
    if (aggr >= 0 && aggr != v) begin
      expTests = AW + $countones(aggr);
      check(nReq == expTests, "R4 test count", nReq, expTests);
      check(found === 1'b1, "R6 found", int'(found), 1);
      check(int'(foundAddr) == aggr, "R6 address", int'(foundAddr), aggr);
      check($signed(foundOffset) == (aggr - v),
            midStart ? "R8 offset uses original victim" : "R6 offset",
            int'($signed(foundOffset)), aggr - v);
    end else begin
      check(nReq == 2, "R5 test count", nReq, 2);
      check(found === 1'b0, "R5 not found", int'(found), 0);
    end
    @(negedge clk);
    check(doneValid === 1'b0 && busy === 1'b0, "R6 single done pulse", int'(doneValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R1 busy", int'(busy), 0);
    check(reqValid === 1'b0, "R1 reqValid", int'(reqValid), 0);
    check(doneValid === 1'b0, "R1 doneValid", int'(doneValid), 0);
    rstN = 1'b1;
    for (int v = 0; v < ROW; v++) begin
      for (int a = 0; a < ROW; a++) begin
        if (a != v) runCase(v, a, 1'b0);
      end
      runCase(v, -1, 1'b0);
    end
    runCase(3, 12, 1'b1);
    runCase(14, 1, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule